// File: doc/BRIEF.md
# Security-Banked Binary Point and Priority Register File

This block is the register file of one processor-side port of an interrupt controller. Software reaches it through a small request/response bus. Each request carries a byte offset, a write flag, write data and a flag that marks the access as secure or non-secure. The block holds four items: a control word, a primary binary point, a second binary point kept for non-secure software, and the running priority. The running priority is loaded by neighbouring logic that acknowledges and completes interrupts.

The binary point is banked by security state. Secure software always sees the primary copy. What non-secure software sees depends on a "shared binary point" bit in the control word. When the bit is clear, non-secure software reads and writes its own copy. When the bit is set, non-secure software reads a value derived from the primary copy, and its writes are dropped.

The running priority reads back as 0xff whenever it holds its idle code. A build for the older revision can turn this mapping off. Every request is answered one cycle later with registered read data. No request is ever refused or answered with an error, including requests to offsets that hold no register.

Top module: `cpuif_bank_regs`

## Requirements
- R1: After reset the control word reads 0, the primary binary point reads MIN_BPR, the non-secure binary point reads MIN_ABPR, the running priority holds 0x100, and rsp_valid is low until a request arrives.
- R2: Each cycle with req_valid high produces rsp_valid high in the following cycle, and only then. In that response cycle rsp_rdata carries the register value from the request cycle for a read, and zero for a write.
- R3: At offset 0x08, a secure write stores max(wdata[2:0], MIN_BPR) into the primary binary point, and a secure read returns that value in bits [2:0].
- R4: A non-secure read of offset 0x08 while control bit 4 (shared binary point) is 1 returns min(primary + 1, 7).
- R5: A non-secure read of offset 0x08 while control bit 4 is 0 returns the non-secure binary point.
- R6: A non-secure write to offset 0x08 while control bit 4 is 1 changes neither binary point.
- R7: A non-secure write to offset 0x08 while control bit 4 is 0 stores max(wdata[2:0], MIN_ABPR) into the non-secure copy and leaves the primary copy unchanged.
- R8: Offset 0x14 reads the running priority, which is loaded from rp_value when rp_load is high. A value above 0xff reads as 0xff unless LEGACY_REV is 1, in which case the raw 9-bit value is returned.
- R9: A read of any offset other than 0x00, 0x08 or 0x14 returns zero. A write to such an offset changes no register.
- R10: With SEC_EXT = 0 the secure flag is ignored, and every access to offset 0x08 reads and writes the primary binary point.
- R11: Offset 0x00 is the control word. Only bit 0 (enable) and bit 4 (shared binary point) are stored; every other bit reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | DATA_W | Write data |
| req_secure | input | 1 | 1 = secure access |
| rp_load | input | 1 | Load the running priority |
| rp_value | input | PRIO_W | New running priority (0x100 and above = idle) |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_rdata | output | DATA_W | Registered read data |

## Verification
The bench builds two copies of the block. The first has the security extension present, the legacy exemption off and default minimums. With it the bench walks the non-secure view through both settings of the shared bit, including the saturation at 7 and the dropped writes. The second has no security extension, the legacy exemption on and MIN_BPR = 2. This brings the upward clamp of the primary copy, the secure flag being ignored, and the raw return of an idle priority within reach of the checks.

// File: rtl/cpuif_bank_pkg.sv
package cpuif_bank_pkg;

    // Width of a stored binary point field
    localparam int unsigned BP_W = 3;

    // Register offsets (software-visible)
    localparam int unsigned OFF_CTRL = 'h00;
    localparam int unsigned OFF_BP   = 'h08;
    localparam int unsigned OFF_RPRI = 'h14;

    // Control word bit positions
    localparam int unsigned CTRL_EN_BIT     = 0;
    localparam int unsigned CTRL_SHARED_BIT = 4;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_BP,
        SEL_RPRI
    } reg_sel_e;

    typedef struct packed {
        logic shared_bp;
        logic enable;
    } ctrl_t;

    // Raise a written binary point to its floor
    function automatic logic [BP_W-1:0] bp_clamp(input logic [BP_W-1:0] v,
                                                 input logic [BP_W-1:0] floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction

    // Non-secure view of the primary binary point when sharing is on
    function automatic logic [BP_W-1:0] bp_shared_view(input logic [BP_W-1:0] prim);
        return (prim == {BP_W{1'b1}}) ? prim : prim + 1'b1;
    endfunction

endpackage

// File: rtl/cpuif_ctrl_reg.sv
module cpuif_ctrl_reg
    import cpuif_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  wr_enable,
    input  logic  wr_shared,
    output ctrl_t ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q.enable    <= wr_enable;
            ctrl_q.shared_bp <= wr_shared;
        end
    end

endmodule

// File: rtl/cpuif_bp_bank.sv
module cpuif_bp_bank
    import cpuif_bank_pkg::*;
#(
    parameter bit SEC_EXT  = 1'b1,
    parameter int MIN_BPR  = 0,
    parameter int MIN_ABPR = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            acc_secure,
    input  logic            shared_bp,
    input  logic [BP_W-1:0] wr_val,
    output logic [BP_W-1:0] rd_view
);

    localparam logic [BP_W-1:0] PRIM_FLOOR  = BP_W'(MIN_BPR);
    localparam logic [BP_W-1:0] ALIAS_FLOOR = BP_W'(MIN_ABPR);

    logic [BP_W-1:0] prim_q;
    logic [BP_W-1:0] alias_q;
    logic            eff_secure;

    generate
        if (SEC_EXT) begin : g_sec
            assign eff_secure = acc_secure;
        end else begin : g_nosec
            assign eff_secure = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q  <= PRIM_FLOOR;
            alias_q <= ALIAS_FLOOR;
        end else if (wr_en) begin
            if (eff_secure) begin
                prim_q <= bp_clamp(wr_val, PRIM_FLOOR);
            end else if (!shared_bp) begin
                alias_q <= bp_clamp(wr_val, ALIAS_FLOOR);
            end
        end
    end

    always_comb begin
        if (eff_secure)      rd_view = prim_q;
        else if (shared_bp)  rd_view = bp_shared_view(prim_q);
        else                 rd_view = alias_q;
    end

    AST_PRIM_FLOOR: assert property (@(posedge clk) disable iff (rst)
        prim_q >= PRIM_FLOOR); // R3
    AST_ALIAS_FLOOR: assert property (@(posedge clk) disable iff (rst)
        alias_q >= ALIAS_FLOOR); // R7
    AST_NS_SHARED_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !eff_secure && shared_bp) |=> ($stable(alias_q) && $stable(prim_q))); // R6
    AST_NS_KEEPS_PRIM: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !eff_secure) |=> $stable(prim_q)); // R7

endmodule

// File: rtl/cpuif_run_prio.sv
module cpuif_run_prio #(
    parameter int DATA_W     = 32,
    parameter int PRIO_W     = 9,
    parameter bit LEGACY_REV = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PRIO_W-1:0] value,
    output logic [DATA_W-1:0] rd_view
);

    localparam logic [PRIO_W-1:0] IDLE_CODE = PRIO_W'(1) << 8;
    localparam logic [DATA_W-1:0] IDLE_VIEW = DATA_W'(8'hff);

    logic [PRIO_W-1:0] prio_q;
    logic              is_idle;

    always_ff @(posedge clk) begin
        if (rst)        prio_q <= IDLE_CODE;
        else if (load)  prio_q <= value;
    end

    assign is_idle = |prio_q[PRIO_W-1:8];

    generate
        if (LEGACY_REV) begin : g_legacy
            assign rd_view = DATA_W'(prio_q);
        end else begin : g_modern
            assign rd_view = is_idle ? IDLE_VIEW : DATA_W'(prio_q);
        end
    endgenerate

    AST_PRIO_LOADS: assert property (@(posedge clk) disable iff (rst)
        load |=> (prio_q == $past(value))); // R8

endmodule

// File: rtl/cpuif_bank_regs.sv
module cpuif_bank_regs
    import cpuif_bank_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int PRIO_W     = 9,
    parameter bit SEC_EXT    = 1'b1,
    parameter bit LEGACY_REV = 1'b0,
    parameter int MIN_BPR    = 0,
    parameter int MIN_ABPR   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_secure,
    input  logic              rp_load,
    input  logic [PRIO_W-1:0] rp_value,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_BP   = ADDR_W'(OFF_BP);
    localparam logic [ADDR_W-1:0] A_RPRI = ADDR_W'(OFF_RPRI);

    reg_sel_e          sel;
    ctrl_t             ctrl;
    logic [BP_W-1:0]   bp_view;
    logic [DATA_W-1:0] rp_view;
    logic [DATA_W-1:0] rd_mux;
    logic              wr_ctrl;
    logic              wr_bp;
    logic              unused_wdata;

    assign unused_wdata = ^{req_wdata[DATA_W-1:5], req_wdata[3]};

    always_comb begin
        if (req_addr == A_CTRL)       sel = SEL_CTRL;
        else if (req_addr == A_BP)    sel = SEL_BP;
        else if (req_addr == A_RPRI)  sel = SEL_RPRI;
        else                          sel = SEL_NONE;
    end

    assign wr_ctrl = req_valid && req_write && (sel == SEL_CTRL);
    assign wr_bp   = req_valid && req_write && (sel == SEL_BP);

    cpuif_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_ctrl),
        .wr_enable (req_wdata[CTRL_EN_BIT]),
        .wr_shared (req_wdata[CTRL_SHARED_BIT]),
        .ctrl_q    (ctrl)
    );

    cpuif_bp_bank #(
        .SEC_EXT  (SEC_EXT),
        .MIN_BPR  (MIN_BPR),
        .MIN_ABPR (MIN_ABPR)
    ) u_bp (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_bp),
        .acc_secure (req_secure),
        .shared_bp  (ctrl.shared_bp),
        .wr_val     (req_wdata[BP_W-1:0]),
        .rd_view    (bp_view)
    );

    cpuif_run_prio #(
        .DATA_W     (DATA_W),
        .PRIO_W     (PRIO_W),
        .LEGACY_REV (LEGACY_REV)
    ) u_rp (
        .clk     (clk),
        .rst     (rst),
        .load    (rp_load),
        .value   (rp_value),
        .rd_view (rp_view)
    );

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_CTRL: begin
                rd_mux[CTRL_EN_BIT]     = ctrl.enable;
                rd_mux[CTRL_SHARED_BIT] = ctrl.shared_bp;
            end
            SEL_BP:   rd_mux[BP_W-1:0] = bp_view;
            SEL_RPRI: rd_mux = rp_view;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rd_mux : '0;
        end
    end

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R2
    AST_WRITE_RSP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> (rsp_rdata == '0)); // R2
    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && sel == SEL_NONE) |=> (rsp_rdata == '0)); // R9

    generate
        if (!LEGACY_REV) begin : g_idle_chk
            AST_RPRI_CAPPED: assert property (@(posedge clk) disable iff (rst)
                (req_valid && !req_write && sel == SEL_RPRI)
                |=> (rsp_rdata[DATA_W-1:8] == '0)); // R8
        end
    endgenerate

endmodule

// File: tb/sim_cpuif_bank_regs.sv
module sim_cpuif_bank_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vld0 = 1'b0, vld1 = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        sec = 1'b0;
    logic        rp_load = 1'b0;
    logic [8:0]  rp_value = '0;
    logic        rv0, rv1;
    logic [31:0] rd0, rd1;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    cpuif_bank_regs #(.SEC_EXT(1'b1), .LEGACY_REV(1'b0)) u0 (
        .clk(clk), .rst(rst), .req_valid(vld0), .req_write(wr), .req_addr(addr),
        .req_wdata(wdata), .req_secure(sec), .rp_load(rp_load), .rp_value(rp_value),
        .rsp_valid(rv0), .rsp_rdata(rd0));

    cpuif_bank_regs #(.SEC_EXT(1'b0), .LEGACY_REV(1'b1), .MIN_BPR(2)) u1 (
        .clk(clk), .rst(rst), .req_valid(vld1), .req_write(wr), .req_addr(addr),
        .req_wdata(wdata), .req_secure(sec), .rp_load(rp_load), .rp_value(rp_value),
        .rsp_valid(rv1), .rsp_rdata(rd1));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One request on instance inst; returns the response data
    task automatic acc(input int inst, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input logic s, output logic [31:0] rd);
        @(negedge clk);
        vld0 = (inst == 0); vld1 = (inst == 1);
        wr = w; addr = a; wdata = d; sec = s;
        @(negedge clk);
        vld0 = 1'b0; vld1 = 1'b0;
        rd = (inst == 0) ? rd0 : rd1;
        check("R2 rsp_valid after request", {31'd0, (inst == 0) ? rv0 : rv1}, 32'd1);
        if (w) check("R2 write response data", rd, 32'd0);
    endtask

    task automatic rd_chk(input int inst, input logic [7:0] a, input logic s,
                          input logic [31:0] exp, input string tag);
        logic [31:0] r;
        acc(inst, 1'b0, a, '0, s, r);
        check(tag, r, exp);
    endtask

    task automatic wr_do(input int inst, input logic [7:0] a, input logic [31:0] d, input logic s);
        logic [31:0] r;
        acc(inst, 1'b1, a, d, s, r);
    endtask

    task automatic load_prio(input logic [8:0] v);
        @(negedge clk);
        rp_load = 1'b1; rp_value = v;
        @(negedge clk);
        rp_load = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 rsp_valid low u0", {31'd0, rv0}, 32'd0);
        check("R1 rsp_valid low u1", {31'd0, rv1}, 32'd0);
        rd_chk(0, 8'h00, 1'b1, 32'h0,   "R1 ctrl reset");
        rd_chk(0, 8'h08, 1'b1, 32'h0,   "R1 primary bp reset");
        rd_chk(0, 8'h08, 1'b0, 32'h1,   "R1 non-secure bp reset");
        rd_chk(0, 8'h14, 1'b1, 32'hff,  "R1 idle priority reads 0xff");
        rd_chk(1, 8'h08, 1'b1, 32'h2,   "R1 primary bp reset at MIN_BPR=2");
        rd_chk(1, 8'h14, 1'b1, 32'h100, "R1 legacy idle code raw");
        @(negedge clk);
        check("R2 no response without request", {31'd0, rv0}, 32'd0);
    endtask

    task automatic t_secure_bp;
        wr_do(0, 8'h08, 32'hFFFF_FF0D, 1'b1);
        rd_chk(0, 8'h08, 1'b1, 32'h5, "R3 secure write low bits stored");
        wr_do(1, 8'h08, 32'h0, 1'b1);
        rd_chk(1, 8'h08, 1'b1, 32'h2, "R3 clamp up to MIN_BPR");
    endtask

    task automatic t_ns_private;
        rd_chk(0, 8'h08, 1'b0, 32'h1, "R5 non-secure reads own copy");
        wr_do(0, 8'h08, 32'h0, 1'b0);
        rd_chk(0, 8'h08, 1'b0, 32'h1, "R7 clamp up to MIN_ABPR");
        wr_do(0, 8'h08, 32'h6, 1'b0);
        rd_chk(0, 8'h08, 1'b0, 32'h6, "R7 non-secure write stored");
        rd_chk(0, 8'h08, 1'b1, 32'h5, "R7 primary untouched");
    endtask

    task automatic t_ns_shared;
        wr_do(0, 8'h00, 32'h10, 1'b1);
        rd_chk(0, 8'h08, 1'b0, 32'h6, "R4 shared view primary+1");
        wr_do(0, 8'h08, 32'h7, 1'b1);
        rd_chk(0, 8'h08, 1'b0, 32'h7, "R4 shared view saturates at 7");
        wr_do(0, 8'h08, 32'h3, 1'b1);
        rd_chk(0, 8'h08, 1'b0, 32'h4, "R4 shared view of 3");
        wr_do(0, 8'h08, 32'h2, 1'b0);
        rd_chk(0, 8'h08, 1'b1, 32'h3, "R6 primary unchanged by dropped write");
        wr_do(0, 8'h00, 32'h0, 1'b1);
        rd_chk(0, 8'h08, 1'b0, 32'h6, "R6 own copy unchanged by dropped write");
    endtask

    task automatic t_prio;
        load_prio(9'h042);
        rd_chk(0, 8'h14, 1'b0, 32'h42,  "R8 priority value");
        rd_chk(1, 8'h14, 1'b0, 32'h42,  "R8 legacy priority value");
        load_prio(9'h1FF);
        rd_chk(0, 8'h14, 1'b1, 32'hff,  "R8 idle above 0xff");
        rd_chk(1, 8'h14, 1'b1, 32'h1FF, "R8 legacy returns raw");
        load_prio(9'h0FF);
        rd_chk(0, 8'h14, 1'b1, 32'hff,  "R8 0xff is a real priority");
    endtask

    task automatic t_undef;
        rd_chk(0, 8'h40, 1'b1, 32'h0, "R9 undefined offset reads zero");
        rd_chk(0, 8'h09, 1'b1, 32'h0, "R9 unaligned offset reads zero");
        wr_do(0, 8'h0C, 32'hFFFF_FFFF, 1'b1);
        wr_do(0, 8'h40, 32'hFFFF_FFFF, 1'b0);
        rd_chk(0, 8'h08, 1'b1, 32'h3, "R9 primary unchanged");
        rd_chk(0, 8'h08, 1'b0, 32'h6, "R9 own copy unchanged");
        rd_chk(0, 8'h00, 1'b1, 32'h0, "R9 ctrl unchanged");
    endtask

    task automatic t_nosec;
        wr_do(1, 8'h08, 32'h6, 1'b0);
        rd_chk(1, 8'h08, 1'b1, 32'h6, "R10 flagged non-secure write hits primary");
        wr_do(1, 8'h00, 32'h10, 1'b0);
        rd_chk(1, 8'h08, 1'b0, 32'h6, "R10 no derived view without extension");
    endtask

    task automatic t_ctrl;
        wr_do(0, 8'h00, 32'hFFFF_FFFF, 1'b1);
        rd_chk(0, 8'h00, 1'b1, 32'h11, "R11 only bits 0 and 4 stored");
        wr_do(0, 8'h00, 32'h1, 1'b1);
        rd_chk(0, 8'h00, 1'b0, 32'h1, "R11 enable bit alone");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_secure_bp;
        t_ns_private;
        t_ns_shared;
        t_prio;
        t_undef;
        t_nosec;
        t_ctrl;
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule